// File: doc/BRIEF.md
# PCI Configuration Address Encoder

This block converts a configuration access request into what a host bridge needs to issue that access through a 16 MB configuration aperture. The request is a bus number, a device/function byte and a register offset. The block returns two values. The first is the byte offset inside the aperture. The second is the 16-bit map word that programs the aperture's cycle type and upper address bits.

Requests on bus 0 target the local segment and produce a type 0 cycle. The device is chosen by a single select bit. For low slot numbers that bit sits in the aperture offset. For higher slots it moves into the map word, because the aperture is too small to hold it. Requests on any other bus produce a type 1 cycle, which carries bus, device and function in the offset.

A request is taken on a one-cycle strobe, and the result appears one clock later. Values outside the 8-bit range are flagged as errors and yield zero outputs.

Top module: `cfg_addr_encoder`

## Requirements
- R1: After reset, rspValid and rspErr are low and rspAddr and rspMap are zero.
- R2: rspValid is high in the cycle after each cycle with reqValid high, and low in the cycle after a cycle with reqValid low.
- R3: With reqBus equal to 0 and slot (reqDevFn bits 7:3) of 12 or less, rspAddr equals (function << 8) | (1 << (slot + 11)) plus reqOffset, where function is reqDevFn bits 2:0, and rspMap equals 0x000A (type code 101 in bits 3:1, bit 0 clear).
- R4: With reqBus equal to 0 and slot from 13 to 20, rspAddr equals (function << 8) plus reqOffset with no select bit, and rspMap equals 0x000A with bit (slot - 5) also set.
- R5: With reqBus equal to 0 and slot from 21 to 31, the select bit falls beyond the 16-bit map word: rspAddr equals (function << 8) plus reqOffset and rspMap equals 0x000A.
- R6: With reqBus from 1 to 255, rspAddr equals (reqBus << 16) | (reqDevFn << 8) plus reqOffset and rspMap equals 0x000B (type code 101, bit 0 set).
- R7: If any of reqBus, reqDevFn or reqOffset exceeds 255, rspErr is high and rspAddr and rspMap are zero; otherwise rspErr is low.
- R8: rspAddr, rspMap and rspErr keep their values in cycles that follow a cycle without reqValid, whatever the request inputs do.
- R9: A type 0 response carries at most one device select bit across rspAddr bits 23:11 and rspMap bits 15:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, one cycle per request |
| reqBus | input | IN_W (16) | Bus number |
| reqDevFn | input | IN_W (16) | Device (bits 7:3) and function (bits 2:0) |
| reqOffset | input | IN_W (16) | Configuration register byte offset |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspErr | output | 1 | Out-of-range request |
| rspAddr | output | ADDR_W (24) | Offset inside the configuration aperture |
| rspMap | output | MAP_W (16) | Map word: select bits, cycle type, low-address enable |

## Verification
Type 0 requests are walked through slots 0, 12, 13, 20, 21 and 31. Each of these sits on one side of a split point: select bit in the offset, select bit in the map word, or select bit lost past the map width. An off-by-one in either shift shows up here.

Type 1 requests cover bus 1 with zero fields and bus 255 with all fields at their maximum, which shows whether the fields overlap or are truncated. Out-of-range values are applied to each input on its own, to check the error path for each one. Idle cycles with changing inputs, and back-to-back requests, separate correct holding from correct updating.

// File: rtl/cfg_enc_pkg.sv
package cfg_enc_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // take a new request this cycle
    logic fault;     // request is out of range, load zeroes
  } encStrobes_t;

  localparam logic [2:0] CFG_TYPE_CODE = 3'b101;
  localparam int         FIELD_MAX     = 255;
  localparam int         SLOT_SPLIT    = 12;
endpackage

// File: rtl/cfg_enc_ctrl.sv
module cfg_enc_ctrl
  import cfg_enc_pkg::*;
#(
  parameter int IN_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reqValid,
  input  logic [IN_W-1:0] reqBus,
  input  logic [IN_W-1:0] reqDevFn,
  input  logic [IN_W-1:0] reqOffset,
  output encStrobes_t     strb,
  output logic            rspValid,
  output logic            rspErr
);
  logic outOfRange;

  generate
    if (IN_W > 8) begin : g_range
      localparam int HI_W = IN_W - 8;
      assign outOfRange = (reqBus[IN_W-1:8]    != {HI_W{1'b0}}) ||
                          (reqDevFn[IN_W-1:8]  != {HI_W{1'b0}}) ||
                          (reqOffset[IN_W-1:8] != {HI_W{1'b0}});
    end else begin : g_norange
      logic unusedIn;
      assign unusedIn   = ^{reqBus, reqDevFn, reqOffset};
      assign outOfRange = 1'b0 & unusedIn;
    end
  endgenerate

  always_comb begin
    strb.capture = reqValid;
    strb.fault   = reqValid && outOfRange;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      rspValid <= reqValid;
      if (strb.capture) rspErr <= strb.fault;
    end
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspValid);                                      // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !rspValid);                                    // R2
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> $stable(rspErr));                              // R8
endmodule

// File: rtl/cfg_enc_dp.sv
module cfg_enc_dp
  import cfg_enc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int MAP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  encStrobes_t       strb,
  input  logic [7:0]        busLo,
  input  logic [7:0]        devFnLo,
  input  logic [7:0]        offsetLo,
  output logic [ADDR_W-1:0] addrQ,
  output logic [MAP_W-1:0]  mapQ
);
  localparam int SEL_BASE  = 11;  // first address bit used for select
  localparam int MAP_SHIFT = 5;   // map bit = slot - MAP_SHIFT

  logic [4:0]        slot;
  logic [2:0]        func;
  logic [31:0]       baseAddr;
  logic [31:0]       mapWide;
  logic [31:0]       sumAddr;
  logic [ADDR_W-1:0] addrNext;
  logic [MAP_W-1:0]  mapNext;

  assign slot = devFnLo[7:3];
  assign func = devFnLo[2:0];

  always_comb begin
    if (busLo == 8'd0) begin
      baseAddr = {21'd0, func, 8'd0};
      mapWide  = {28'd0, CFG_TYPE_CODE, 1'b0};
      if (int'(slot) <= SLOT_SPLIT)
        baseAddr = baseAddr | (32'd1 << (int'(slot) + SEL_BASE));
      else
        mapWide  = mapWide | (32'd1 << (int'(slot) - MAP_SHIFT));
    end else begin
      baseAddr = {8'd0, busLo, devFnLo, 8'd0};
      mapWide  = {28'd0, CFG_TYPE_CODE, 1'b1};
    end
    sumAddr  = baseAddr + {24'd0, offsetLo};
    addrNext = sumAddr[ADDR_W-1:0];
    mapNext  = mapWide[MAP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ <= '0;
      mapQ  <= '0;
    end else if (strb.capture) begin
      addrQ <= strb.fault ? '0 : addrNext;
      mapQ  <= strb.fault ? '0 : mapNext;
    end
  end

  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.capture |=> ($stable(addrQ) && $stable(mapQ)));        // R8
  AST_TYPE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.capture && !strb.fault) |=> (mapQ[3:1] == CFG_TYPE_CODE)); // R3
  AST_LOCAL_LOWBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.capture && !strb.fault && busLo == 8'd0) |=> !mapQ[0]);    // R4
endmodule

// File: rtl/cfg_addr_encoder.sv
module cfg_addr_encoder
  import cfg_enc_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int ADDR_W = 24,
  parameter int MAP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [IN_W-1:0]   reqBus,
  input  logic [IN_W-1:0]   reqDevFn,
  input  logic [IN_W-1:0]   reqOffset,
  output logic              rspValid,
  output logic              rspErr,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [MAP_W-1:0]  rspMap
);
  encStrobes_t strb;

  cfg_enc_ctrl #(.IN_W(IN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid),
    .reqBus(reqBus), .reqDevFn(reqDevFn), .reqOffset(reqOffset),
    .strb(strb), .rspValid(rspValid), .rspErr(rspErr)
  );

  cfg_enc_dp #(.ADDR_W(ADDR_W), .MAP_W(MAP_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .busLo(reqBus[7:0]), .devFnLo(reqDevFn[7:0]), .offsetLo(reqOffset[7:0]),
    .addrQ(rspAddr), .mapQ(rspMap)
  );

  AST_ERR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    rspErr |-> (rspAddr == '0 && rspMap == '0));                 // R7
  AST_SINGLE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && !rspErr && !rspMap[0]) |->
      ($countones({rspAddr[ADDR_W-1:11], rspMap[MAP_W-1:4]}) <= 1)); // R9
endmodule

// File: tb/cfg_addr_encoder_test.sv
module cfg_addr_encoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] reqBus = '0, reqDevFn = '0, reqOffset = '0;
  logic        rspValid, rspErr;
  logic [23:0] rspAddr;
  logic [15:0] rspMap;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // reference state
  bit          expValid = 0, expErr = 0;
  int unsigned expAddr = 0, expMap = 0;

  always #10 clk = ~clk;  // 50 MHz

  cfg_addr_encoder uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid),
    .reqBus(reqBus), .reqDevFn(reqDevFn), .reqOffset(reqOffset),
    .rspValid(rspValid), .rspErr(rspErr), .rspAddr(rspAddr), .rspMap(rspMap)
  );

  task automatic check(input string tag, input int unsigned act, input int unsigned exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // behavioural model of one request
  task automatic model(input int bus, input int devfn, input int off);
    int slot, fn;
    if (bus > 255 || devfn > 255 || off > 255) begin
      expErr = 1; expAddr = 0; expMap = 0;
      return;
    end
    expErr = 0;
    slot = devfn / 8;
    fn   = devfn % 8;
    if (bus == 0) begin
      expAddr = fn * 256 + off;
      expMap  = 10;
      if (slot <= 12) expAddr = expAddr + (1 << (slot + 11));
      else if (slot - 5 < 16) expMap = expMap + (1 << (slot - 5));
    end else begin
      expAddr = bus * 65536 + devfn * 256 + off;
      expMap  = 11;
    end
  endtask

  function automatic int popcnt(input int unsigned v);
    int c = 0;
    for (int i = 0; i < 32; i++) c += (v >> i) & 1;
    return c;
  endfunction

  // drive one cycle, then compare after the edge
  task automatic step(input bit req, input int bus, input int devfn, input int off,
                      input string tag);
    @(negedge clk);
    reqValid  = req;
    reqBus    = 16'(bus);
    reqDevFn  = 16'(devfn);
    reqOffset = 16'(off);
    @(posedge clk);
    expValid = req;
    if (req) model(bus, devfn, off);
    @(negedge clk);
    reqValid = 1'b0;
    check({"R2 ", tag}, rspValid, expValid);
    check({tag, " err"},  rspErr,  expErr);
    check({tag, " addr"}, rspAddr, expAddr);
    check({tag, " map"},  rspMap,  expMap);
    if (req && !expErr && !rspMap[0])
      check("R9 single select", (popcnt({8'd0, rspAddr[23:11]}) + popcnt(rspMap[15:4])) <= 1, 1);
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", rspValid, 0);
    check("R1 err",   rspErr,   0);
    check("R1 addr",  rspAddr,  0);
    check("R1 map",   rspMap,   0);
    rst_n = 1'b1;

    step(1, 0, 8'h00, 0,    "R3 slot0");
    step(1, 0, 8'h67, 8'hFC, "R3 slot12");
    step(1, 0, 8'h68, 8'h10, "R4 slot13");
    step(1, 0, 8'hA3, 8'h04, "R4 slot20");
    step(1, 0, 8'hA9, 8'h08, "R5 slot21");
    step(1, 0, 8'hFF, 8'hFF, "R5 slot31");
    step(1, 1, 8'h00, 0,    "R6 bus1");
    step(1, 255, 8'hFF, 8'hFF, "R6 bus255");
    step(1, 3, 8'h2A, 8'h40, "R6 bus3");
    // idle with wandering inputs: everything holds
    step(0, 0, 8'h10, 8'h20, "R8 idle");
    step(0, 300, 999, 512, "R8 idle junk");
    step(1, 256, 0, 0,      "R7 bus");
    step(0, 0, 0, 0,        "R8 err hold");
    step(1, 0, 256, 0,      "R7 devfn");
    step(1, 0, 0, 256,      "R7 offset");
    step(1, 0, 8'h08, 0,    "R7 recover");
    // back to back, every slot on bus 0 and a few remote
    for (int s = 0; s < 32; s++) step(1, 0, s * 8 + (s % 8), s, "R3/R4/R5 sweep");
    for (int b = 1; b < 256; b += 37) step(1, b, (b * 7) % 256, (b * 3) % 256, "R6 sweep");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule